// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps the single atomic reservation of a 32-bit processor core. A load-with-reservation records the word it read. A later store-conditional to that same word may write memory only while the reservation is still standing. The monitor sees decoded memory operations on two ports. The issue port carries any memory operation leaving the pipeline: reserving loads, conditional stores and ordinary stores. The drain port carries only ordinary stores that retire from the store buffer.

For each conditional store, the monitor gives the memory port a write enable and gives the status register a condition-flag update. Both appear combinationally in the same cycle as the operation. The reservation state changes on the next clock edge. Any ordinary store of byte, half or word size that touches the reserved word cancels the reservation. A conditional store cancels it whether the store succeeds or fails.

When both ports are active in the same cycle, the drain store's cancellation is applied first. The issue operation is then evaluated against the result. A reserving load therefore survives a simultaneous drain store to its own word, and a conditional store fails if a simultaneous drain store hits the reserved word.

Top module: `resv_monitor`

## Requirements
- R1: Operations are classified from the 6-bit primary opcode. 0x1B is a reserving load and 0x33 is a conditional store, both on the issue port only. 0x35, 0x36 and 0x37 are ordinary word, byte and half stores on either port. Any other opcode, or any operation whose valid strobe is low, changes no state and drives no output.
- R2: After reset no reservation is held, so a conditional store fails even at address 0.
- R3: A reserving load sets the reservation and records its effective address with the low two bits dropped, which is the word address.
- R4: A conditional store drives flag_we high in the same cycle. flag_val is high exactly when a reservation is held and the store's word address equals the reserved word address.
- R5: sc_wr_en is high in the same cycle as a conditional store only when that store succeeds. It is never high otherwise.
- R6: Every conditional store clears the reservation, whether it succeeds or fails.
- R7: An ordinary store on either port whose word address equals the reserved word address clears the reservation. An ordinary store to any other word leaves the reservation intact.
- R8: A drain store's clear is applied before the issue operation in the same cycle. A simultaneous reserving load leaves the new reservation set, and a simultaneous conditional store to the reserved word fails.
- R9: flag_we and sc_wr_en stay low in every cycle without a valid conditional store on the issue port.
- R10: A second reserving load replaces the recorded word address, and only the newest word can then succeed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue-port operation strobe |
| iss_opcode | input | 6 | Issue-port primary opcode |
| iss_addr | input | 32 | Issue-port effective address |
| drn_valid | input | 1 | Drain-port store strobe |
| drn_opcode | input | 6 | Drain-port primary opcode |
| drn_addr | input | 32 | Drain-port effective address |
| sc_wr_en | output | 1 | Conditional store may write memory |
| flag_we | output | 1 | Condition flag update strobe |
| flag_val | output | 1 | Condition flag value (store succeeded) |

## Verification
The in-RTL assertions check every cycle for the following: a write enable never appears without a successful flag, outputs stay idle without a conditional store, the reservation is set after a reserving load and cleared after any conditional store, and a hitting drain store empties it unless a reserving load arrives with it. The reservation's effect over time can only be seen by running the bench's scenarios. These cover the match masking of sub-word addresses, survival across stores to other words, replacement by a newer load, and the same-cycle ordering between the two ports, each visible only through the outcome of a later conditional store.

// File: rtl/resv_pkg.sv
package resv_pkg;

    localparam int ADDR_W   = 32;
    localparam int OPC_W    = 6;
    localparam int WORD_LSB = 2;
    localparam int WADDR_W  = ADDR_W - WORD_LSB;

    localparam logic [OPC_W-1:0] OPC_LOAD_RESV  = 6'h1B;
    localparam logic [OPC_W-1:0] OPC_STORE_COND = 6'h33;
    localparam logic [OPC_W-1:0] OPC_STORE_W    = 6'h35;
    localparam logic [OPC_W-1:0] OPC_STORE_B    = 6'h36;
    localparam logic [OPC_W-1:0] OPC_STORE_H    = 6'h37;

    typedef enum logic [1:0] {
        MOP_NONE  = 2'd0,
        MOP_LRESV = 2'd1,
        MOP_SCOND = 2'd2,
        MOP_STORE = 2'd3
    } mop_e;

    typedef struct packed {
        logic               held;
        logic [WADDR_W-1:0] waddr;
    } resv_t;

    function automatic logic [WADDR_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:WORD_LSB];
    endfunction

endpackage

// File: rtl/resv_decode.sv
module resv_decode
    import resv_pkg::*;
#(
    parameter bit ATOMIC_OK = 1'b1
) (
    input  logic             valid,
    input  logic [OPC_W-1:0] opcode,
    output mop_e             mop
);
    always_comb begin
        mop = MOP_NONE;
        if (valid) begin
            unique case (opcode)
                OPC_STORE_W, OPC_STORE_B, OPC_STORE_H: mop = MOP_STORE;
                OPC_LOAD_RESV:  mop = ATOMIC_OK ? MOP_LRESV : MOP_NONE;
                OPC_STORE_COND: mop = ATOMIC_OK ? MOP_SCOND : MOP_NONE;
                default:        mop = MOP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/resv_match.sv
module resv_match
    import resv_pkg::*;
(
    input  logic               held,
    input  logic [WADDR_W-1:0] resv_waddr,
    input  logic [WADDR_W-1:0] op_waddr,
    output logic               hit
);
    assign hit = held && (resv_waddr == op_waddr);
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [OPC_W-1:0]  iss_opcode,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic              drn_valid,
    input  logic [OPC_W-1:0]  drn_opcode,
    input  logic [ADDR_W-1:0] drn_addr,
    output logic              sc_wr_en,
    output logic              flag_we,
    output logic              flag_val
);
    resv_t        resv_q, resv_d;
    mop_e         iss_mop, drn_mop;
    logic         drn_hit, iss_hit;
    logic         held_after_drain;
    logic         unused_lsbs;

    assign unused_lsbs = ^{iss_addr[WORD_LSB-1:0], drn_addr[WORD_LSB-1:0]};

    resv_decode #(.ATOMIC_OK(1'b1)) u_dec_iss (
        .valid (iss_valid), .opcode (iss_opcode), .mop (iss_mop)
    );
    resv_decode #(.ATOMIC_OK(1'b0)) u_dec_drn (
        .valid (drn_valid), .opcode (drn_opcode), .mop (drn_mop)
    );

    // Drain port is compared against the registered reservation.
    resv_match u_match_drn (
        .held (resv_q.held), .resv_waddr (resv_q.waddr),
        .op_waddr (word_of(drn_addr)), .hit (drn_hit)
    );

    // Drain clear is applied before the issue operation is judged.
    assign held_after_drain = resv_q.held && !(drn_mop == MOP_STORE && drn_hit);

    resv_match u_match_iss (
        .held (held_after_drain), .resv_waddr (resv_q.waddr),
        .op_waddr (word_of(iss_addr)), .hit (iss_hit)
    );

    always_comb begin
        flag_we  = (iss_mop == MOP_SCOND);
        flag_val = flag_we && iss_hit;
        sc_wr_en = flag_val;
    end

    always_comb begin
        resv_d      = resv_q;
        resv_d.held = held_after_drain;
        unique case (iss_mop)
            MOP_LRESV: begin
                resv_d.held  = 1'b1;
                resv_d.waddr = word_of(iss_addr);
            end
            MOP_SCOND: resv_d.held = 1'b0;
            MOP_STORE: if (iss_hit) resv_d.held = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resv_q <= '0;
        end else begin
            resv_q <= resv_d;
        end
    end

    // R5: a write enable only accompanies a successful flag update
    a_r5_wr_needs_success: assert property (@(posedge clk) disable iff (rst)
        sc_wr_en |-> (flag_we && flag_val));

    // R9: idle outputs without a valid conditional store opcode
    a_r9_idle_outputs: assert property (@(posedge clk) disable iff (rst)
        !(iss_valid && iss_opcode == OPC_STORE_COND) |-> (!flag_we && !sc_wr_en));

    // R3: reserving load leaves a held reservation on its word
    a_r3_load_sets: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_opcode == OPC_LOAD_RESV) |=>
            (resv_q.held && resv_q.waddr == $past(iss_addr[ADDR_W-1:WORD_LSB])));

    // R6: any conditional store leaves no reservation
    a_r6_sc_clears: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_opcode == OPC_STORE_COND) |=> !resv_q.held);

    // R7/R8: a hitting drain store clears unless a reserving load arrives with it
    a_r7_drain_clears: assert property (@(posedge clk) disable iff (rst)
        (drn_mop == MOP_STORE && drn_hit && iss_mop != MOP_LRESV) |=> !resv_q.held);

    // R2: first cycle out of reset holds nothing
    a_r2_reset_empty: assert property (@(posedge clk)
        $past(rst) |-> !resv_q.held);

endmodule

// File: tb/resv_monitor_tb.sv
module resv_monitor_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    logic [5:0]  iss_opcode = '0;
    logic [31:0] iss_addr = '0;
    logic        drn_valid = 1'b0;
    logic [5:0]  drn_opcode = '0;
    logic [31:0] drn_addr = '0;
    logic        sc_wr_en, flag_we, flag_val;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [5:0] LR = 6'h1B, SC = 6'h33, SW = 6'h35, SB = 6'h36, SH = 6'h37;

    always #5 clk = ~clk;

    resv_monitor u_dut (
        .clk, .rst, .iss_valid, .iss_opcode, .iss_addr,
        .drn_valid, .drn_opcode, .drn_addr,
        .sc_wr_en, .flag_we, .flag_val
    );

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {wr,we,val} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One cycle on both ports; returns {sc_wr_en, flag_we, flag_val} sampled mid-cycle.
    task automatic step(input logic iv, input logic [5:0] iop, input logic [31:0] ia,
                        input logic dv, input logic [5:0] dop, input logic [31:0] da,
                        output logic [2:0] res);
        @(negedge clk);
        iss_valid = iv; iss_opcode = iop; iss_addr = ia;
        drn_valid = dv; drn_opcode = dop; drn_addr = da;
        #1;
        res = {sc_wr_en, flag_we, flag_val};
    endtask

    task automatic iss(input logic [5:0] op, input logic [31:0] a, output logic [2:0] res);
        step(1'b1, op, a, 1'b0, 6'h0, 32'h0, res);
    endtask

    task automatic t_reset();
        logic [2:0] r;
        iss(SC, 32'h0, r);           chk("R2 sc after reset", r, 3'b010);
    endtask

    task automatic t_basic();
        logic [2:0] r;
        iss(LR, 32'h100, r);         chk("R9 load outputs idle", r, 3'b000);
        iss(SC, 32'h100, r);         chk("R4 R5 matched sc", r, 3'b111);
        iss(SC, 32'h100, r);         chk("R6 second sc fails", r, 3'b010);
        iss(LR, 32'h200, r);
        iss(SC, 32'h204, r);         chk("R4 other word fails", r, 3'b010);
        iss(SC, 32'h200, r);         chk("R6 failed sc cleared", r, 3'b010);
        iss(LR, 32'h303, r);
        iss(SC, 32'h300, r);         chk("R3 word address masking", r, 3'b111);
    endtask

    task automatic t_store_clear();
        logic [2:0] r;
        iss(LR, 32'h400, r);
        iss(SB, 32'h402, r);         chk("R9 byte store outputs idle", r, 3'b000);
        iss(SC, 32'h400, r);         chk("R7 byte store same word clears", r, 3'b010);
        iss(LR, 32'h400, r);
        iss(SH, 32'h408, r);
        iss(SW, 32'h3FC, r);
        iss(SC, 32'h400, r);         chk("R7 other words keep reservation", r, 3'b111);
        iss(LR, 32'h480, r);
        step(1'b0, 6'h0, 32'h0, 1'b1, SW, 32'h481, r);
        iss(SC, 32'h480, r);         chk("R7 drain store clears", r, 3'b010);
    endtask

    task automatic t_same_cycle();
        logic [2:0] r;
        step(1'b1, LR, 32'h500, 1'b1, SW, 32'h500, r);
        iss(SC, 32'h500, r);         chk("R8 load wins over drain clear", r, 3'b111);
        iss(LR, 32'h600, r);
        step(1'b1, SC, 32'h600, 1'b1, SB, 32'h601, r);
        chk("R8 drain clear before sc", r, 3'b010);
        iss(LR, 32'h680, r);
        step(1'b1, SC, 32'h680, 1'b1, SH, 32'h684, r);
        chk("R8 drain other word keeps sc", r, 3'b111);
    endtask

    task automatic t_replace();
        logic [2:0] r;
        iss(LR, 32'h700, r);
        iss(LR, 32'h800, r);
        iss(SC, 32'h800, r);         chk("R10 newest word succeeds", r, 3'b111);
        iss(LR, 32'h700, r);
        iss(LR, 32'h800, r);
        iss(SC, 32'h700, r);         chk("R10 older word fails", r, 3'b010);
    endtask

    task automatic t_ignore();
        logic [2:0] r;
        iss(LR, 32'h900, r);
        iss(6'h34, 32'h900, r);      chk("R1 unknown opcode idle", r, 3'b000);
        step(1'b0, SW, 32'h900, 1'b0, SW, 32'h900, r);
        chk("R9 invalid store idle", r, 3'b000);
        step(1'b0, SC, 32'h900, 1'b0, 6'h0, 32'h0, r);
        chk("R9 invalid sc idle", r, 3'b000);
        step(1'b0, 6'h0, 32'h0, 1'b1, SC, 32'h900, r);
        chk("R1 sc on drain port idle", r, 3'b000);
        iss(SC, 32'h900, r);         chk("R1 ignored ops kept reservation", r, 3'b111);
        step(1'b0, LR, 32'hA00, 1'b0, 6'h0, 32'h0, r);
        iss(SC, 32'hA00, r);         chk("R1 invalid load sets nothing", r, 3'b010);
        step(1'b0, 6'h0, 32'h0, 1'b1, LR, 32'hB00, r);
        iss(SC, 32'hB00, r);         chk("R1 load on drain port ignored", r, 3'b010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_store_clear();
        t_same_cycle();
        t_replace();
        t_ignore();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule